// File: doc/BRIEF.md
# External Memory Bank Gate

This block holds the control registers of an asynchronous external memory port and decides, from a bus address, which of the memory banks that address belongs to. A small register bus (byte offset, read and write strobes, access-size code, write data, read data, error flag) reaches three registers. The first is a 16-bit global control word, whose field of bits [3:1] sets how many banks are switched on. The other two are 32-bit bank-timing words that are stored and read back but not interpreted here.

The bank gate splits the space above a base address into equal windows, one per bank. The window size is 1 MiB or 64 MiB, chosen by a parameter. An address inside the window of an enabled bank drives that bank's select line. Any other address drives the "no bank" output instead. A write to the global word changes the set of live banks on the next clock edge, with no other step. Out-of-map offsets and wrongly sized accesses to the global word raise a one-cycle error and have no other effect.

Top module: `xmem_bank_gate`

## Requirements
- R1: After reset the global word reads 0x00F2 and both bank-timing words read 0xFFC2FFC2. With 0x00F2 only bank 0 is enabled.
- R2: The global word at offset 0 accepts only size code 1 (16 bits). With size code 0, 2 or 3 an access raises reg_err. A write with a wrong size leaves the word unchanged, and a read with a wrong size returns zero.
- R3: The bank-timing words sit at offsets 4 and 8. A write with any size code stores all 32 bits of reg_wdata, and a read returns that value unchanged.
- R4: An access to any offset other than 0, 4 or 8 raises reg_err and returns zero read data. A write there changes no register.
- R5: reg_err is high only in a cycle where reg_wr or reg_rd is high. reg_rdata is zero in every cycle without an error-free read.
- R6: The enabled bank count is bits [3:1] of the global word. Field values 5, 6 and 7 count as 4.
- R7: Bank i covers addresses BASE + i*2^S up to BASE + (i+1)*2^S - 1. S is 20 when WIDE_BANKS is 0 and 26 when it is 1. Addresses below BASE, or at or above BASE + 4*2^S, belong to no bank.
- R8: bank_sel is one-hot (bit i for bank i) when the address lies in the window of a bank whose index is below the enabled count. In every other case it is all zero.
- R9: bank_none is high exactly when bank_sel is all zero.
- R10: A register write takes effect at the clock edge that ends the strobe cycle. In the strobe cycle itself the bank gate still uses the old global word.
- R11: A read and a write to the same register in one cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | OFF_W (4) | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| reg_err | output | 1 | Access error, valid in the strobe cycle |
| bus_addr | input | ADDR_W (32) | External bus address to classify |
| bank_sel | output | NUM_BANKS (4) | One-hot bank select |
| bank_none | output | 1 | Address hits no enabled bank |

## Verification
Two functions can fall in the same cycle: a write to the global word and the classification of a bus address. The bench provokes this by writing a new bank count while bus_addr already points into a bank that the write turns on or off. It expects the old result in the strobe cycle and the new result in the following cycle. A read and a write to the same register in one cycle are provoked in the same way, and the read must return the old value.

// File: rtl/xbg_pkg.sv
package xbg_pkg;

   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_WORD = 2'd2,
      XS_RSVD = 2'd3
   } xsize_e;

   localparam int XBG_DATA_W   = 32;
   localparam int XBG_GLB_W    = 16;
   localparam int XBG_CNT_W    = 3;
   localparam int XBG_CNT_LSB  = 1;
   localparam int XBG_SZ_NARROW = 20;
   localparam int XBG_SZ_WIDE   = 26;

   localparam logic [XBG_GLB_W-1:0]  XBG_GLB_RST  = 16'h00F2;
   localparam logic [XBG_DATA_W-1:0] XBG_BCTL_RST = 32'hFFC2_FFC2;

endpackage

// File: rtl/xbg_regs.sv
module xbg_regs
   import xbg_pkg::*;
#(
   parameter int OFF_W    = 4,
   parameter int NUM_BCTL = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [OFF_W-1:0]      reg_addr,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [1:0]            reg_size,
   input  logic [XBG_DATA_W-1:0] reg_wdata,
   output logic [XBG_DATA_W-1:0] reg_rdata,
   output logic                  reg_err,
   output logic [XBG_GLB_W-1:0]  glb_ctl
);

   localparam int MAP_BYTES = 4 * (NUM_BCTL + 1);

   generate
      if (MAP_BYTES > (1 << OFF_W)) begin : g_bad_off_w
         $error("OFF_W too narrow for the register map");
      end
   endgenerate

   xsize_e                 size_q;
   logic                   hit_glb;
   logic [NUM_BCTL-1:0]    hit_bctl;
   logic                   size_ok;
   logic                   access;
   logic                   bad;
   logic [XBG_GLB_W-1:0]   glb_q;
   logic [XBG_DATA_W-1:0]  bctl_q [NUM_BCTL];

   assign size_q  = xsize_e'(reg_size);
   assign hit_glb = (reg_addr == '0);
   assign size_ok = (size_q == XS_HALF);
   assign access  = reg_wr | reg_rd;
   assign bad     = access & ~((hit_glb & size_ok) | (|hit_bctl));
   assign reg_err = bad;
   assign glb_ctl = glb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q <= XBG_GLB_RST;
      end else if (reg_wr && hit_glb && size_ok) begin
         glb_q <= reg_wdata[XBG_GLB_W-1:0];
      end
   end

   generate
      for (genvar j = 0; j < NUM_BCTL; j++) begin : g_bctl
         assign hit_bctl[j] = (reg_addr == OFF_W'(4 * (j + 1)));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bctl_q[j] <= XBG_BCTL_RST;
            end else if (reg_wr && hit_bctl[j]) begin
               bctl_q[j] <= reg_wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (reg_rd && !bad) begin
         if (hit_glb) begin
            reg_rdata = {{(XBG_DATA_W-XBG_GLB_W){1'b0}}, glb_q};
         end
         for (int j = 0; j < NUM_BCTL; j++) begin
            if (hit_bctl[j]) begin
               reg_rdata = bctl_q[j];
            end
         end
      end
   end

   AST_GLB_BADSIZE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0 && reg_size != 2'd1) |=> $stable(glb_q)) // R2
      else $error("global word changed on wrongly sized write");

   AST_ERR_ZERO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> (reg_rdata == '0)) // R4
      else $error("read data not zero on error");

endmodule

// File: rtl/xbg_decode.sv
module xbg_decode
   import xbg_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BASE     = 32'h2000_0000,
   parameter bit              WIDE_BANKS = 1'b0,
   parameter int              NUM_BANKS  = 4
) (
   input  logic [XBG_GLB_W-1:0] glb_ctl,
   input  logic [ADDR_W-1:0]    bus_addr,
   output logic [NUM_BANKS-1:0] bank_sel,
   output logic                 bank_none
);

   localparam logic [XBG_CNT_W-1:0] CNT_MAX = XBG_CNT_W'(NUM_BANKS);

   logic [ADDR_W-1:0]    off;
   logic [ADDR_W-1:0]    idx;
   logic                 below;
   logic [XBG_CNT_W-1:0] field;
   logic [XBG_CNT_W-1:0] cnt;

   assign below = (bus_addr < BASE);
   assign off   = bus_addr - BASE;

   generate
      if (WIDE_BANKS) begin : g_wide
         assign idx = off >> XBG_SZ_WIDE;
      end else begin : g_narrow
         assign idx = off >> XBG_SZ_NARROW;
      end
   endgenerate

   assign field = glb_ctl[XBG_CNT_LSB +: XBG_CNT_W];
   assign cnt   = (field > CNT_MAX) ? CNT_MAX : field;

   generate
      for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
         assign bank_sel[i] = !below && (idx == ADDR_W'(i)) &&
                              (XBG_CNT_W'(i) < cnt);
      end
   endgenerate

   assign bank_none = below || (idx >= ADDR_W'(cnt));

endmodule

// File: rtl/xmem_bank_gate.sv
module xmem_bank_gate
   import xbg_pkg::*;
#(
   parameter int                OFF_W      = 4,
   parameter int                ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BASE       = 32'h2000_0000,
   parameter bit                WIDE_BANKS = 1'b0,
   parameter int                NUM_BANKS  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [OFF_W-1:0]      reg_addr,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [1:0]            reg_size,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   output logic                  reg_err,
   input  logic [ADDR_W-1:0]     bus_addr,
   output logic [NUM_BANKS-1:0]  bank_sel,
   output logic                  bank_none
);

   localparam int SZ_LOG2 = WIDE_BANKS ? XBG_SZ_WIDE : XBG_SZ_NARROW;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 7) begin : g_bad_banks
         $error("NUM_BANKS must be 1..7");
      end
      if (ADDR_W <= SZ_LOG2 + 2) begin : g_bad_addr_w
         $error("ADDR_W too small for the bank windows");
      end
   endgenerate

   logic [XBG_GLB_W-1:0] glb_ctl;

   xbg_regs #(
      .OFF_W    (OFF_W),
      .NUM_BCTL (2)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_size  (reg_size),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .reg_err   (reg_err),
      .glb_ctl   (glb_ctl)
   );

   xbg_decode #(
      .ADDR_W     (ADDR_W),
      .BASE       (BASE),
      .WIDE_BANKS (WIDE_BANKS),
      .NUM_BANKS  (NUM_BANKS)
   ) u_decode (
      .glb_ctl   (glb_ctl),
      .bus_addr  (bus_addr),
      .bank_sel  (bank_sel),
      .bank_none (bank_none)
   );

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel)) // R8
      else $error("bank_sel not one-hot");

   AST_NONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      bank_none != (|bank_sel)) // R9
      else $error("bank_none disagrees with bank_sel");

   AST_ERR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> (reg_wr || reg_rd)) // R5
      else $error("error without a strobe");

   AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr < BASE) |-> bank_none) // R7
      else $error("address below base selected a bank");

endmodule

// File: tb/xmem_bank_gate_bench.sv
module xmem_bank_gate_bench;

   localparam logic [31:0] BASE = 32'h2000_0000;
   localparam int          SZ   = 20;
   localparam logic [31:0] WIN  = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_size = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_err;
   logic [31:0] bus_addr = '0;
   logic [3:0]  bank_sel;
   logic        bank_none;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] m_glb;
   logic [31:0] m_b [2];

   always #4 clk = ~clk;

   xmem_bank_gate u_xmem_bank_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_size  (reg_size),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .reg_err   (reg_err),
      .bus_addr  (bus_addr),
      .bank_sel  (bank_sel),
      .bank_none (bank_none)
   );

   function automatic logic [3:0] exp_sel(logic [15:0] g, logic [31:0] a);
      longint unsigned idx;
      int en;
      en = int'((g >> 1) & 16'h7);
      if (en > 4) en = 4;
      if (a < BASE) return 4'b0;
      idx = longint'(a - BASE) >> SZ;
      if (idx < longint'(en)) return 4'(1 << idx);
      return 4'b0;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] a, input logic wr, input logic rd,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input logic [31:0] ba, input string tag);
      logic        e_err;
      logic [31:0] e_rd;
      logic [3:0]  e_sel;
      @(negedge clk);
      reg_addr = a; reg_wr = wr; reg_rd = rd; reg_size = sz;
      reg_wdata = wd; bus_addr = ba;
      #1;
      e_err = (wr || rd) && !((a == 4'd0 && sz == 2'd1) || a == 4'd4 || a == 4'd8);
      e_rd  = '0;
      if (rd && !e_err) begin
         if (a == 4'd0) e_rd = {16'h0, m_glb};
         else if (a == 4'd4) e_rd = m_b[0];
         else e_rd = m_b[1];
      end
      e_sel = exp_sel(m_glb, ba);
      chk(tag, "reg_err", 32'(reg_err), 32'(e_err));
      chk(tag, "reg_rdata", reg_rdata, e_rd);
      chk(tag, "bank_sel", 32'(bank_sel), 32'(e_sel));
      chk(tag, "bank_none", 32'(bank_none), 32'(e_sel == 4'b0));
      @(posedge clk);
      if (wr && !e_err) begin
         if (a == 4'd0) m_glb = wd[15:0];
         else if (a == 4'd4) m_b[0] = wd;
         else m_b[1] = wd;
      end
   endtask

   task automatic idle(input logic [31:0] ba, input string tag);
      step(4'd0, 1'b0, 1'b0, 2'd0, 32'h0, ba, tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m_glb  = 16'h00F2;
      m_b[0] = 32'hFFC2_FFC2;
      m_b[1] = 32'hFFC2_FFC2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      step(4'd0, 0, 1, 2'd1, 0, BASE, "R1");
      step(4'd4, 0, 1, 2'd2, 0, BASE, "R1");
      step(4'd8, 0, 1, 2'd2, 0, BASE, "R1");
      // R7 R8 R9 windows with only bank 0 on
      idle(BASE + WIN - 1, "R7");
      idle(BASE + WIN, "R8");
      idle(BASE - 1, "R9");
      // R10 enable four banks while pointing at bank 3
      step(4'd0, 1, 0, 2'd1, 32'h0000_0008, BASE + 3*WIN + 5, "R10");
      idle(BASE + 3*WIN + 5, "R10");
      idle(BASE + 4*WIN, "R7");
      // R11 read and write same cycle
      step(4'd0, 1, 1, 2'd1, 32'h0000_000A, BASE + 2*WIN, "R11");
      step(4'd0, 0, 1, 2'd1, 0, BASE + 3*WIN, "R6");
      step(4'd0, 1, 0, 2'd1, 32'h0000_000E, BASE + WIN, "R6");
      idle(BASE + 3*WIN + 32'hFFFFF, "R6");
      step(4'd0, 1, 0, 2'd1, 32'h0000_0004, BASE + 2*WIN, "R6");
      idle(BASE + 2*WIN, "R6");
      idle(BASE + WIN + 7, "R8");
      // R2 wrongly sized global accesses
      step(4'd0, 1, 0, 2'd0, 32'h0000_0008, BASE + 3*WIN, "R2");
      step(4'd0, 1, 0, 2'd2, 32'h0000_0008, BASE + 3*WIN, "R2");
      step(4'd0, 1, 0, 2'd3, 32'h0000_0008, BASE + 3*WIN, "R2");
      step(4'd0, 0, 1, 2'd2, 0, BASE + 3*WIN, "R2");
      step(4'd0, 0, 1, 2'd1, 0, BASE + 3*WIN, "R2");
      // R3 bank-timing words, any size
      step(4'd4, 1, 0, 2'd0, 32'h1234_5678, BASE, "R3");
      step(4'd8, 1, 0, 2'd1, 32'hA5A5_5A5A, BASE, "R3");
      step(4'd4, 0, 1, 2'd0, 0, BASE, "R3");
      step(4'd8, 0, 1, 2'd3, 0, BASE, "R3");
      // R4 invalid offsets
      step(4'd12, 1, 0, 2'd2, 32'hDEAD_BEEF, BASE, "R4");
      step(4'd6, 1, 0, 2'd2, 32'hDEAD_BEEF, BASE, "R4");
      step(4'd2, 1, 0, 2'd1, 32'h0000_000E, BASE, "R4");
      step(4'd12, 0, 1, 2'd2, 0, BASE, "R4");
      step(4'd5, 0, 1, 2'd2, 0, BASE, "R4");
      step(4'd4, 0, 1, 2'd2, 0, BASE, "R4");
      step(4'd8, 0, 1, 2'd2, 0, BASE, "R4");
      step(4'd0, 0, 1, 2'd1, 0, BASE + 2*WIN, "R4");
      // R5 no strobe, no error, zero data
      idle(BASE, "R5");
      step(4'd12, 0, 0, 2'd3, 32'hFFFF_FFFF, BASE, "R5");
      // R8 all banks off, then R10 turn bank 0 back on
      step(4'd0, 1, 0, 2'd1, 32'h0000_0000, BASE, "R10");
      idle(BASE, "R8");
      idle(BASE + 3*WIN, "R8");
      step(4'd0, 1, 0, 2'd1, 32'h0000_0002, BASE + 8, "R10");
      idle(BASE + 8, "R10");
      // sweep of all windows with every count value
      for (int c = 0; c < 8; c++) begin
         step(4'd0, 1, 0, 2'd1, 32'(c << 1), BASE, "R6");
         for (int w = 0; w < 6; w++) begin
            idle(BASE + 32'(w) * WIN + 32'(w * 3), "R8");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule